// File: doc/BRIEF.md
# MDIO Indirect Write Bridge

The block lets a host issue Clause 22 management writes on an MDC/MDIO pair through three host-visible words. A general-purpose data word is loaded first. A control word then names one of two indirect registers and asks for a write to it. One indirect register takes the low half of the data word as the 16-bit write payload. The other takes the PHY and register address pair from the data word and, in the same step, starts the serial frame. The host then watches a ready word until the frame has gone out.

A built-in management responder listens on the same serial lines at one configurable PHY address. It holds five 16-bit registers: control, status, two identifier words and advertisement. Their contents can be read back on a side port, so the written values can be checked end to end. Only writes are supported. Every frame carries a full preamble.

Top module: `mdio_wr_bridge`

## Requirements
- R1: After reset, `rdy_o` reads 0x0001007F, `mdc_o` and `mdio_oe_o` are 0 and `mdio_o` is 1. The responder registers at selects 0..4 read 0x1140, 0x0109, 0x0141, 0x0C54 and 0x05E1.
- R2: A control write (select 1) with bit 15 set and bits [9:0] = 0x3B0 latches bits [15:0] of the current data word (select 0) as the write payload. The upper 16 data-word bits have no effect on the frame.
- R3: A control write with bit 15 set and bits [9:0] = 0x3B4 starts a frame when the bridge is idle. The frame carries PHY address data[9:5], register address data[4:0] and the payload latched earlier, so a data word of 0x62 targets PHY 3, register 2.
- R4: A control write with bit 15 clear, or with any other indirect address, changes neither the payload nor the line state. A host write with select 2 or 3 has no effect either.
- R5: At successive MDC rising edges, MDIO carries 64 bits in this order: 32 ones, 01, 01, PHY[4:0], REG[4:0], 10, then DATA[15:0], each field MSB first.
- R6: MDC has a period of 2*MDC_HALF clock cycles during a frame. MDIO changes only on MDC falling edges.
- R7: From the cycle after a start until the frame ends, `rdy_o` reads 0x0000007B. It returns to 0x0001007F once the last bit has been sent.
- R8: A start request made while a frame is in progress is ignored. The current frame keeps its 64 bits, and `rdy_o` stays at 0x0000007B until that frame ends.
- R9: The responder stores DATA into register REG when the frame's PHY address equals RESP_PHY and REG < 5.
- R10: A frame to another PHY address, or to REG 5 or above, leaves every responder register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_we_i | input | 1 | Host write strobe |
| host_sel_i | input | 2 | Host word select: 0 data word, 1 control word |
| host_wdata_i | input | 32 | Host write data |
| rdy_o | output | 32 | Ready word |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe_o | output | 1 | Management data drive enable |
| pcs_sel_i | input | 3 | Responder register select |
| pcs_data_o | output | 16 | Responder register value |

## Verification
The assertions assume that the host issues at most one write per cycle and that the responder hears only frames from this bridge. They also assume reset is asserted before the first clock edge. The stimulus drives every host write for a single cycle, away from the active clock edge. It waits for the idle ready value before the next start request, except in the one deliberate case that issues a start during a frame. Random PHY and register addresses are drawn so that matching addresses, other addresses and out-of-range registers all occur.

// File: rtl/mdio_pkg.sv
`timescale 1ns/1ps
package mdio_pkg;
  localparam logic [1:0]  SEL_WORD = 2'd0;
  localparam logic [1:0]  SEL_CTRL = 2'd1;
  localparam logic [9:0]  IA_WDATA = 10'h3B0;
  localparam logic [9:0]  IA_START = 10'h3B4;
  localparam logic [31:0] RDY_IDLE = 32'h0001_007F;
  localparam logic [31:0] RDY_BUSY = 32'h0000_007B;
  localparam int unsigned PRE_BITS = 32;
  localparam int unsigned FRM_BITS = 32;

  typedef struct packed {
    logic [4:0]  phy_sel;
    logic [4:0]  reg_idx;
    logic [15:0] data;
  } mgmt_req_t;

  function automatic logic [FRM_BITS-1:0] wr_frame(mgmt_req_t r);
    return {2'b01, 2'b01, r.phy_sel, r.reg_idx, 2'b10, r.data};
  endfunction
endpackage

// File: rtl/mdio_host_regs.sv
`timescale 1ns/1ps
module mdio_host_regs
  import mdio_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [1:0]  wr_sel_i,
  input  logic [31:0] wr_data_i,
  input  logic        busy_i,
  output logic        launch_o,
  output mgmt_req_t   req_o,
  output logic [31:0] rdy_o
);
  logic [31:0] word_q;
  logic [15:0] wdat_q;
  logic        ind_we;
  logic [9:0]  ind_adr;

  assign ind_we   = wr_en_i && (wr_sel_i == SEL_CTRL) && wr_data_i[15];
  assign ind_adr  = wr_data_i[9:0];
  assign launch_o = ind_we && (ind_adr == IA_START) && !busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= '0;
      wdat_q <= '0;
    end else begin
      if (wr_en_i && wr_sel_i == SEL_WORD) word_q <= wr_data_i;
      if (ind_we && ind_adr == IA_WDATA)   wdat_q <= word_q[15:0];
    end
  end

  assign req_o = '{phy_sel: word_q[9:5], reg_idx: word_q[4:0], data: wdat_q};
  assign rdy_o = busy_i ? RDY_BUSY : RDY_IDLE;

  AST_LAUNCH_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_o |=> busy_i); // R3
  AST_RDY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && wr_en_i && wr_sel_i == SEL_CTRL) |=> rdy_o == RDY_BUSY); // R8
endmodule

// File: rtl/mdio_frame_tx.sv
`timescale 1ns/1ps
module mdio_frame_tx
  import mdio_pkg::*;
#(
  parameter int unsigned MDC_HALF = 4
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      launch_i,
  input  mgmt_req_t req_i,
  output logic      busy_o,
  output logic      mdc_o,
  output logic      mdio_o,
  output logic      mdio_oe_o
);
  localparam int unsigned TOT = PRE_BITS + FRM_BITS;
  localparam int unsigned BW  = $clog2(TOT + 1);
  localparam int unsigned CW  = $clog2(MDC_HALF + 1);

  logic [TOT-1:0] sh_q;
  logic [BW-1:0]  left_q;
  logic [CW-1:0]  cnt_q;
  logic           mdc_q;
  logic           busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      left_q <= '0;
      cnt_q  <= '0;
      mdc_q  <= 1'b0;
      busy_q <= 1'b0;
    end else if (launch_i) begin
      sh_q   <= {{PRE_BITS{1'b1}}, wr_frame(req_i)};
      left_q <= BW'(TOT);
      cnt_q  <= '0;
      mdc_q  <= 1'b0;
      busy_q <= 1'b1;
    end else if (busy_q) begin
      if (cnt_q == CW'(MDC_HALF - 1)) begin
        cnt_q <= '0;
        mdc_q <= ~mdc_q;
        if (mdc_q) begin  // falling edge: next bit
          sh_q   <= sh_q << 1;
          left_q <= left_q - 1'b1;
          if (left_q == BW'(1)) busy_q <= 1'b0;
        end
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign busy_o    = busy_q;
  assign mdc_o     = mdc_q;
  assign mdio_o    = busy_q ? sh_q[TOT-1] : 1'b1;
  assign mdio_oe_o = busy_q;

  AST_NO_RELAUNCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_i |-> !busy_q); // R8
  AST_IDLE_LINES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> (mdio_o && !mdc_q)); // R1
  AST_MDIO_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && $past(busy_q) && !$stable(mdio_o)) |-> $fell(mdc_q)); // R6
  AST_MDIO_AT_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mdc_q) |-> $stable(mdio_o)); // R6
endmodule

// File: rtl/mdio_pcs_resp.sv
`timescale 1ns/1ps
module mdio_pcs_resp
  import mdio_pkg::*;
#(
  parameter logic [4:0]            PHY_ADDR = 5'd3,
  parameter int unsigned           NUM_REGS = 5,
  parameter logic [NUM_REGS*16-1:0] RST_VALS = '0,
  localparam int unsigned          SW = $clog2(NUM_REGS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          mdc_i,
  input  logic          mdio_i,
  input  logic [SW-1:0] rd_sel_i,
  output logic [15:0]   rd_data_o
);
  localparam int unsigned OW = $clog2(PRE_BITS + 1);
  localparam int unsigned NW = $clog2(FRM_BITS);

  logic                       mdc_d, smp;
  logic [OW-1:0]              ones_q;
  logic                       in_frm_q, done_q;
  logic [NW-1:0]              n_q;
  logic [FRM_BITS-2:0]        rx_q;
  logic                       hit;
  logic [NUM_REGS-1:0]        reg_we;
  logic [NUM_REGS-1:0][15:0]  regs_q;

  assign smp = mdc_i && !mdc_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mdc_d    <= 1'b0;
      ones_q   <= '0;
      in_frm_q <= 1'b0;
      done_q   <= 1'b0;
      n_q      <= '0;
      rx_q     <= '0;
    end else begin
      mdc_d  <= mdc_i;
      done_q <= smp && in_frm_q && (n_q == NW'(FRM_BITS - 2));
      if (smp) begin
        if (!in_frm_q) begin
          if (mdio_i) begin
            if (ones_q != OW'(PRE_BITS)) ones_q <= ones_q + 1'b1;
          end else begin
            // first start bit after a full preamble
            if (ones_q == OW'(PRE_BITS)) begin
              in_frm_q <= 1'b1;
              n_q      <= '0;
            end
            ones_q <= '0;
          end
        end else begin
          rx_q <= {rx_q[FRM_BITS-3:0], mdio_i};
          n_q  <= n_q + 1'b1;
          if (n_q == NW'(FRM_BITS - 2)) in_frm_q <= 1'b0;
        end
      end
    end
  end

  // rx_q: [30] start, [29:28] op, [27:23] phy, [22:18] reg, [17:16] ta, [15:0] data
  assign hit = done_q && rx_q[30] && (rx_q[29:28] == 2'b01) && (rx_q[17:16] == 2'b10)
            && (rx_q[27:23] == PHY_ADDR) && (rx_q[22:18] < 5'(NUM_REGS));

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_we
    assign reg_we[i] = hit && (rx_q[22:18] == 5'(i));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      regs_q <= RST_VALS;
    end else begin
      for (int i = 0; i < NUM_REGS; i++)
        if (reg_we[i]) regs_q[i] <= rx_q[15:0];
    end
  end

  assign rd_data_o = (rd_sel_i < SW'(NUM_REGS)) ? regs_q[rd_sel_i] : 16'h0000;

  AST_REG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit |=> $stable(regs_q)); // R10
  AST_ONE_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(reg_we)); // R9
endmodule

// File: rtl/mdio_wr_bridge.sv
`timescale 1ns/1ps
module mdio_wr_bridge
  import mdio_pkg::*;
#(
  parameter int unsigned MDC_HALF = 4,
  parameter logic [4:0]  RESP_PHY = 5'd3,
  parameter logic [79:0] PCS_RST  = {16'h05E1, 16'h0C54, 16'h0141, 16'h0109, 16'h1140}
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        host_we_i,
  input  logic [1:0]  host_sel_i,
  input  logic [31:0] host_wdata_i,
  output logic [31:0] rdy_o,
  output logic        mdc_o,
  output logic        mdio_o,
  output logic        mdio_oe_o,
  input  logic [2:0]  pcs_sel_i,
  output logic [15:0] pcs_data_o
);
  logic      launch, busy, mdio_line;
  mgmt_req_t req;

  mdio_host_regs u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (host_we_i),
    .wr_sel_i  (host_sel_i),
    .wr_data_i (host_wdata_i),
    .busy_i    (busy),
    .launch_o  (launch),
    .req_o     (req),
    .rdy_o     (rdy_o)
  );

  mdio_frame_tx #(.MDC_HALF(MDC_HALF)) u_tx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .launch_i  (launch),
    .req_i     (req),
    .busy_o    (busy),
    .mdc_o     (mdc_o),
    .mdio_o    (mdio_o),
    .mdio_oe_o (mdio_oe_o)
  );

  // idle line reads high (pull-up)
  assign mdio_line = mdio_oe_o ? mdio_o : 1'b1;

  mdio_pcs_resp #(.PHY_ADDR(RESP_PHY), .NUM_REGS(5), .RST_VALS(PCS_RST)) u_resp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mdc_i     (mdc_o),
    .mdio_i    (mdio_line),
    .rd_sel_i  (pcs_sel_i),
    .rd_data_o (pcs_data_o)
  );
endmodule

// File: tb/mdio_wr_bridge_tb.sv
`timescale 1ns/1ps
module mdio_wr_bridge_tb;
  localparam int HALF = 4;
  localparam logic [4:0] RESP = 5'd3;
  localparam logic [31:0] IDLE = 32'h0001_007F;
  localparam logic [31:0] BUSY = 32'h0000_007B;

  logic clk = 1'b0, rst_n = 1'b0;
  logic we = 1'b0;
  logic [1:0] sel = 2'd0;
  logic [31:0] wdat = '0;
  logic [31:0] rdy;
  logic mdc, mdio, oe;
  logic [2:0] psel = 3'd0;
  logic [15:0] pdat;

  int checks = 0, fails = 0;
  int cyc = 0, cap_n = 0, last_rise = 0, per_bad = 0;
  logic cap [128];
  logic [15:0] model [5];
  bit done = 0;

  always #4 clk = ~clk;  // 8 ns period
  always @(negedge clk) cyc++;

  mdio_wr_bridge #(.MDC_HALF(HALF), .RESP_PHY(RESP)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .host_we_i(we), .host_sel_i(sel), .host_wdata_i(wdat),
    .rdy_o(rdy), .mdc_o(mdc), .mdio_o(mdio), .mdio_oe_o(oe),
    .pcs_sel_i(psel), .pcs_data_o(pdat));

  always @(posedge mdc) begin
    if (cap_n < 128) cap[cap_n] = mdio;
    if (cap_n > 0 && (cyc - last_rise) != 2 * HALF) per_bad++;
    last_rise = cyc;
    cap_n++;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_frame(logic [4:0] p, logic [4:0] r, logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, 2'b01, p, r, 2'b10, d};
  endfunction

  task automatic host_wr(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk); we = 1'b1; sel = s; wdat = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 4000 && rdy != IDLE; k++) @(negedge clk);
  endtask

  task automatic check_regs(input string req);
    for (int i = 0; i < 5; i++) begin
      psel = 3'(i); #1;
      chk(pdat == model[i], req, 64'(pdat), 64'(model[i]));
    end
  endtask

  task automatic check_frame(input logic [4:0] p, input logic [4:0] r, input logic [15:0] d, input string req);
    logic [63:0] got, exp;
    exp = exp_frame(p, r, d);
    got = '0;
    for (int i = 0; i < 64; i++) got[63-i] = cap[i];
    chk(cap_n == 64, {req, " bit count"}, 64'(cap_n), 64'd64);
    chk(got == exp, {req, " frame bits"}, got, exp);
    chk(per_bad == 0, "R6 mdc period", 64'(per_bad), 64'd0);
  endtask

  // payload, then address pair and start; optional start attempt while busy
  task automatic mgmt_write(input logic [4:0] p, input logic [4:0] r, input logic [31:0] d, input bit poke);
    host_wr(2'd0, d);
    host_wr(2'd1, 32'h0000_83B0);
    host_wr(2'd0, {22'd0, p, r});
    cap_n = 0; per_bad = 0;
    host_wr(2'd1, 32'h0000_83B4);
    chk(rdy == BUSY, "R7 ready while busy", 64'(rdy), 64'(BUSY));
    if (poke) begin
      repeat (40) @(negedge clk);
      host_wr(2'd0, {22'd0, ~p, ~r});
      host_wr(2'd1, 32'h0000_83B4);
      chk(rdy == BUSY, "R8 ready kept busy", 64'(rdy), 64'(BUSY));
    end
    wait_idle();
    chk(rdy == IDLE, "R7 ready after frame", 64'(rdy), 64'(IDLE));
    check_frame(p, r, d[15:0], poke ? "R8" : "R5");
    if (p == RESP && r < 5) model[r] = d[15:0];
    check_regs((p == RESP && r < 5) ? "R9 responder write" : "R10 responder untouched");
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [4:0] p, r;
    logic [31:0] d;
    void'($urandom(32'd1357));
    model[0] = 16'h1140; model[1] = 16'h0109; model[2] = 16'h0141;
    model[3] = 16'h0C54; model[4] = 16'h05E1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(rdy == IDLE, "R1 ready", 64'(rdy), 64'(IDLE));
    chk({mdc, oe, mdio} == 3'b001, "R1 lines", 64'({mdc, oe, mdio}), 64'd1);
    check_regs("R1 responder reset");

    // R3 directed: 0xABCD to PHY 3 reg 2 via address word 0x62
    mgmt_write(5'd3, 5'd2, 32'h0000_ABCD, 1'b0);

    // R2 upper data-word bits dropped
    mgmt_write(RESP, 5'd0, 32'hFFFF_1234, 1'b0);

    // R4 ignored control words and selects keep payload 0x5A5A
    host_wr(2'd0, 32'h0000_5A5A);
    host_wr(2'd1, 32'h0000_83B0);
    host_wr(2'd0, 32'h0000_C3C3);
    host_wr(2'd1, 32'h0000_03B0);
    host_wr(2'd1, 32'h0000_83B8);
    host_wr(2'd2, 32'h0000_83B0);
    host_wr(2'd3, 32'h0000_83B4);
    chk(rdy == IDLE && oe == 1'b0, "R4 no start", 64'({rdy, 31'd0, oe}), 64'({IDLE, 32'd0}));
    host_wr(2'd0, {22'd0, RESP, 5'd4});
    cap_n = 0; per_bad = 0;
    host_wr(2'd1, 32'h0000_83B4);
    wait_idle();
    check_frame(RESP, 5'd4, 16'h5A5A, "R4");
    model[4] = 16'h5A5A;
    check_regs("R4 responder");

    // R8 start while busy
    mgmt_write(RESP, 5'd1, 32'h0000_0F0F, 1'b1);

    // R10 directed: wrong PHY, out-of-range register
    mgmt_write(5'd7, 5'd0, 32'h0000_DEAD, 1'b0);
    mgmt_write(RESP, 5'd6, 32'h0000_BEEF, 1'b0);

    // random mix
    for (int n = 0; n < 12; n++) begin
      p = ($urandom % 2) ? RESP : 5'($urandom % 32);
      r = 5'($urandom % 8);
      d = $urandom;
      mgmt_write(p, r, d, 1'b0);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule